// File: doc/BRIEF.md
# Eight-Entry Level-Flagging FIFO

This block is a synchronous first-in first-out buffer of eight entries with a configurable data width. Codec data paths use one instance on each side. It reports `full` and `empty`, a 4-bit occupancy count, and a sticky overflow flag. It also compares the occupancy against a 3-bit programmable mark and raises a level flag.

A parameter sets the direction of that comparison. A buffer that feeds the codec is built with `LOW_MARK = 1`, so the flag rises when few entries remain and the host should refill. A buffer that collects results is built with `LOW_MARK = 0`, so the flag rises when many entries have built up and the host should drain. A synchronous `flush` strobe empties the buffer at once. A separate strobe clears the overflow record.

Occupancy is tracked by a three-state controller:

- `ST_EMPTY`: no entries held.
- `ST_PART`: one to seven entries held.
- `ST_FULL`: all eight entries held.

Its transitions are:

- **fill-start**: `ST_EMPTY` to `ST_PART` on an accepted push.
- **fill-top**: `ST_PART` to `ST_FULL` on a lone push at seven entries.
- **drain-last**: `ST_PART` to `ST_EMPTY` on a lone pop at one entry.
- **drain-top**: `ST_FULL` to `ST_PART` on a pop.
- **flush**: any state to `ST_EMPTY`.

Top module: `lvl_fifo`

## Requirements
- R1: After reset the outputs are `empty`=1, `full`=0, `level`=0, `overflow`=0 and `pop_data`=0.
- R2: `full` is 1 exactly when `level` equals 8; `level` never exceeds 8.
- R3: `empty` is 1 exactly when `level` equals 0.
- R4: A push while `full` is dropped, and `overflow` reads 1 after that edge. When a pop comes in the same cycle, the pop is still served, the pushed word is still dropped and `overflow` is still set.
- R5: `overflow` stays 1 until a cycle with `ovf_clr`=1 and no new overflow. A new overflow in the same cycle as `ovf_clr` leaves it at 1. `flush` does not change it.
- R6: `thresh_flag` follows the current `level` with no added delay. With `LOW_MARK`=1 it is 1 when `level` <= `thresh`. With `LOW_MARK`=0 it is 1 when `level` >= `thresh`.
- R7: `flush` makes `level` 0 and `empty` 1 after the edge. A push or pop in the same cycle is ignored, and `pop_data` keeps its value.
- R8: Entries leave in the order they entered. An accepted pop presents the oldest entry on `pop_data` after the clock edge that takes it.
- R9: A push and a pop in the same cycle, while neither empty nor full, leave `level` unchanged.
- R10: A pop while empty is ignored, and `pop_data` keeps the last value read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Synchronous empty strobe |
| push | input | 1 | Write strobe |
| push_data | input | WIDTH | Word to write |
| pop | input | 1 | Read strobe |
| pop_data | output | WIDTH | Last word read |
| ovf_clr | input | 1 | Overflow clear strobe |
| thresh | input | 3 | Programmable occupancy mark |
| full | output | 1 | Eight entries held |
| empty | output | 1 | No entries held |
| overflow | output | 1 | Sticky record of a dropped push |
| level | output | 4 | Occupancy count, 0 to 8 |
| thresh_flag | output | 1 | Occupancy-versus-mark flag |

## Verification
A controller state that disagrees with the counter shows up at once on `full` or `empty` against `level`, on the first edge after the divergence. A pointer fault is hidden until the damaged slot is read, so it appears on `pop_data` up to eight pops later as a reordered or stale word. The bench therefore compares every popped word against a reference queue across long random runs. A lost overflow update is visible on the very next edge, but only when push-while-full or clear cycles are driven. The directed cases force exactly those cycles.

// File: rtl/lvl_fifo_pkg.sv
package lvl_fifo_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_PART  = 2'd1,
        ST_FULL  = 2'd2
    } occ_state_t;
endpackage

// File: rtl/lvl_fifo_ctrl.sv
module lvl_fifo_ctrl
    import lvl_fifo_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic                         pop,
    input  logic                         ovf_clr,
    output logic                         wr_en,
    output logic [$clog2(DEPTH)-1:0]     wr_ptr,
    output logic                         rd_en,
    output logic [$clog2(DEPTH)-1:0]     rd_ptr,
    output logic [$clog2(DEPTH):0]       level,
    output logic                         full,
    output logic                         empty,
    output logic                         overflow
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] TOP  = CW'(DEPTH);
    localparam logic [CW-1:0] NEAR = CW'(DEPTH - 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    occ_state_t state, state_nx;
    logic       do_push, do_pop, drop;
    logic [CW-1:0] count;

    assign do_push = push && !flush && (state != ST_FULL);
    assign do_pop  = pop  && !flush && (state != ST_EMPTY);
    assign drop    = push && !flush && (state == ST_FULL);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        if (flush) begin
            state_nx = ST_EMPTY;
        end else begin
            unique case (state)
                ST_EMPTY: if (do_push) state_nx = ST_PART;
                ST_PART: begin
                    if (do_push && !do_pop && count == NEAR)
                        state_nx = ST_FULL;
                    else if (do_pop && !do_push && count == CW'(1))
                        state_nx = ST_EMPTY;
                end
                ST_FULL:  if (do_pop) state_nx = ST_PART;
                default:  state_nx = ST_EMPTY;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        full  = 1'b0;
        empty = 1'b0;
        unique case (state)
            ST_EMPTY: empty = 1'b1;
            ST_PART:  ;
            ST_FULL:  full = 1'b1;
            default:  empty = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (flush) begin
            count  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       overflow <= 1'b0;
        else if (drop)    overflow <= 1'b1;
        else if (ovf_clr) overflow <= 1'b0;
    end

    assign wr_en = do_push;
    assign rd_en = do_pop;
    assign level = count;

    a_r2_full_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        (full == (level == TOP)) && (level <= TOP));
    a_r3_empty_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        empty == (level == '0));
    a_r4_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (overflow && level == TOP));
    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !ovf_clr) |=> overflow);
    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (empty && level == '0));
    a_r9_pair_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !flush && !full && !empty) |=> $stable(level));
endmodule

// File: rtl/lvl_fifo_store.sv
module lvl_fifo_store #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_ptr,
    input  logic [WIDTH-1:0]         wr_data,
    input  logic                     rd_en,
    input  logic [$clog2(DEPTH)-1:0] rd_ptr,
    output logic [WIDTH-1:0]         rd_data
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_ptr];
    end

    a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/lvl_fifo_mark.sv
module lvl_fifo_mark #(
    parameter int CW       = 4,
    parameter int TW       = 3,
    parameter bit LOW_MARK = 1'b1
) (
    input  logic [CW-1:0] level,
    input  logic [TW-1:0] thresh,
    output logic          flag
);
    localparam int XW = (CW > TW) ? CW : TW;
    logic [XW-1:0] lv, th;
    assign lv = XW'(level);
    assign th = XW'(thresh);

    generate
        if (LOW_MARK) begin : g_low
            assign flag = (lv <= th);
        end else begin : g_high
            assign flag = (lv >= th);
        end
    endgenerate
endmodule

// File: rtl/lvl_fifo.sv
module lvl_fifo #(
    parameter int WIDTH    = 16,
    parameter int TW       = 3,
    parameter bit LOW_MARK = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    input  logic             ovf_clr,
    input  logic [TW-1:0]    thresh,
    output logic             full,
    output logic             empty,
    output logic             overflow,
    output logic [3:0]       level,
    output logic             thresh_flag
);
    localparam int DEPTH = 8;
    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = AW + 1;

    logic          wr_en, rd_en;
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] lvl;

    lvl_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .pop(pop),
        .ovf_clr(ovf_clr), .wr_en(wr_en), .wr_ptr(wr_ptr), .rd_en(rd_en),
        .rd_ptr(rd_ptr), .level(lvl), .full(full), .empty(empty),
        .overflow(overflow)
    );

    lvl_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ptr(wr_ptr),
        .wr_data(push_data), .rd_en(rd_en), .rd_ptr(rd_ptr), .rd_data(pop_data)
    );

    lvl_fifo_mark #(.CW(CW), .TW(TW), .LOW_MARK(LOW_MARK)) u_mark (
        .level(lvl), .thresh(thresh), .flag(thresh_flag)
    );

    assign level = lvl;

    a_r7_flush_holds_data: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> $stable(pop_data));
    a_r10_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !flush) |=> $stable(pop_data));
endmodule

// File: tb/lvl_fifo_tb.sv
module lvl_fifo_tb;
    localparam int PERIOD = 10;
    localparam int W = 16;

    logic clk = 0, rst_n = 0;
    logic flush = 0, push = 0, pop = 0, ovf_clr = 0;
    logic [W-1:0] push_data = '0;
    logic [2:0] thresh = 3'd3;
    logic [W-1:0] pd_lo, pd_hi;
    logic full, empty, overflow, flag_lo, flag_hi;
    logic full_h, empty_h, ovf_h;
    logic [3:0] level, level_h;

    int checks = 0, fails = 0;
    logic [W-1:0] mq[$];
    logic [W-1:0] m_last = '0;
    logic m_ovf = 0;

    always #(PERIOD/2) clk = ~clk;

    lvl_fifo #(.WIDTH(W), .LOW_MARK(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .push_data(push_data),
        .pop(pop), .pop_data(pd_lo), .ovf_clr(ovf_clr), .thresh(thresh),
        .full(full), .empty(empty), .overflow(overflow), .level(level),
        .thresh_flag(flag_lo));

    lvl_fifo #(.WIDTH(W), .LOW_MARK(1'b0)) u_dut_hi (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .push_data(push_data),
        .pop(pop), .pop_data(pd_hi), .ovf_clr(ovf_clr), .thresh(thresh),
        .full(full_h), .empty(empty_h), .overflow(ovf_h), .level(level_h),
        .thresh_flag(flag_hi));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_flag(input int cnt, input int thr, input bit low);
        return low ? int'(cnt <= thr) : int'(cnt >= thr);
    endfunction

    task automatic check_all();
        int n = mq.size();
        chk("R2 full", int'(full), int'(n == 8));
        chk("R3 empty", int'(empty), int'(n == 0));
        chk("R9 level", int'(level), n);
        chk("R5 overflow", int'(overflow), int'(m_ovf));
        chk("R8 pop_data", int'(pd_lo), int'(m_last));
        chk("R6 low flag", int'(flag_lo), exp_flag(n, int'(thresh), 1'b1));
        chk("R6 high flag", int'(flag_hi), exp_flag(n, int'(thresh), 1'b0));
    endtask

    task automatic step(input bit ps, input bit pp, input bit fl, input bit cl,
                        input logic [W-1:0] d, input logic [2:0] th);
        bit was_full;
        push = ps; pop = pp; flush = fl; ovf_clr = cl; push_data = d; thresh = th;
        @(posedge clk);
        #1;
        was_full = (mq.size() == 8);
        if (fl) begin
            mq.delete();
            if (cl) m_ovf = 0;
        end else begin
            if (pp && mq.size() > 0) m_last = mq.pop_front();
            if (ps && !was_full) mq.push_back(d);
            if (ps && was_full) m_ovf = 1;
            else if (cl) m_ovf = 0;
        end
        push = 0; pop = 0; flush = 0; ovf_clr = 0;
        check_all();
    endtask

    initial begin
        #(PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd20240611);
        #(PERIOD * 3);
        rst_n = 1;
        @(posedge clk); #1;
        // R1 reset state
        chk("R1 empty", int'(empty), 1);
        chk("R1 full", int'(full), 0);
        chk("R1 level", int'(level), 0);
        chk("R1 overflow", int'(overflow), 0);
        chk("R1 pop_data", int'(pd_lo), 0);

        // R10 pop on empty
        step(0, 1, 0, 0, 16'h0, 3'd0);
        // fill to eight, then overflow (R2, R4)
        for (int i = 0; i < 8; i++) step(1, 0, 0, 0, W'(16'h100 + i), 3'(i));
        step(1, 0, 0, 0, 16'hDEAD, 3'd7);
        chk("R4 dropped overflow", int'(overflow), 1);
        // R4 push plus pop while full
        step(1, 1, 0, 0, 16'hBEEF, 3'd7);
        // R5 set wins over clear
        step(1, 0, 0, 0, 16'h0001, 3'd5);
        step(1, 1, 0, 1, 16'h0002, 3'd5);
        // R5 flush keeps overflow, R7 flush ignores push/pop
        step(1, 1, 1, 0, 16'h0003, 3'd2);
        chk("R7 flushed level", int'(level), 0);
        chk("R5 flush keeps ovf", int'(overflow), 1);
        step(0, 0, 0, 1, 16'h0, 3'd0);
        // R9 push+pop in the middle
        step(1, 0, 0, 0, 16'hA1, 3'd1);
        step(1, 0, 0, 0, 16'hA2, 3'd1);
        step(1, 1, 0, 0, 16'hA3, 3'd2);
        step(0, 1, 0, 0, 16'h0, 3'd2);
        step(0, 1, 0, 0, 16'h0, 3'd2);
        step(0, 1, 0, 0, 16'h0, 3'd2);

        // random phase
        for (int k = 0; k < 4000; k++) begin
            int unsigned r;
            bit bias;
            r = $urandom;
            bias = (k / 200) % 2;
            step(bias ? (r[3:0] < 11) : (r[3:0] < 5),
                 bias ? (r[7:4] < 5) : (r[7:4] < 11),
                 (r[15:8] == 8'd7),
                 (r[19:16] == 4'd3),
                 W'($urandom), 3'(r[26:24]));
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule